// File: doc/BRIEF.md
# ISA Capability Register

This block holds the machine-level register that tells software which instruction-set extensions the core offers. Each of the lower 26 bits stands for one extension letter. The bit position is the letter minus `A`. The top two bits of the read value give the native register width. At reset the register takes a build-time maximum capability. The supervisor and user mode bits are always part of that maximum.

Software may write the register to switch off some optional extensions, or to switch them back on. Only a fixed group of optional extensions can change, and only those present in the maximum. Each write passes through a legaliser first, so an illegal combination can never be stored. The current enable bits are driven out to the rest of the core. This block does not gate any decoders itself.

Top module: `isa_cap_reg`

## Requirements
- R1: Extension letter L maps to bit position (L minus `A`) in both `ext_en` and `rd_data[25:0]`, so M is bit 12, F is bit 5, D is bit 3 and C is bit 2.
- R2: While reset is asserted, and in the first cycle after it, the stored value equals the maximum capability: `MAX_EXT` with S (bit 18) and U (bit 20) also set.
- R3: No bit outside the maximum capability is ever set, whatever is written.
- R4: Only M, A, F, D and C (bits 12, 0, 5, 3, 2) that are also in the maximum can change on a write. Every other bit keeps its value.
- R5: A write whose data has F (bit 5) clear stores D (bit 3) clear, whatever D was in the written data.
- R6: On a write, each writable bit takes the written bit, after the D-without-F rule is applied.
- R7: `rd_data[XLEN-1:XLEN-2]` reads 1 when XLEN is 32 and 2 when XLEN is 64. Bits `XLEN-3` down to 26 read zero.
- R8: A write takes effect at the clock edge where `wr_en` is high. Without a write the value holds. `rd_data` shows the stored value combinationally, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | XLEN | Value to be written (legalised before storage) |
| rd_data | output | XLEN | Current register value, width field in the top two bits |
| ext_en | output | 26 | Current per-letter extension enables |

## Verification
The in-RTL properties check four things on every cycle:
- no bit outside the maximum capability is ever set;
- every non-writable bit stays at its reset value;
- a write with F clear always leaves D clear, and a write with F set copies the writable bits;
- the register holds when no write occurs, and reset release shows the full capability.

Some behaviour only the bench's scenarios can show:
- the letter-to-bit mapping;
- the constant width field;
- that writing all ones brings no bit back beyond the maximum;
- that re-enabling an extension after it was disabled works.

The bench's reference model finds these through directed writes and a long run of random writes.

// File: rtl/isa_cap_pkg.sv
package isa_cap_pkg;

   localparam int EXT_W = 26;

   typedef logic [EXT_W-1:0] ext_vec_t;

   // bit position of an extension letter: letter minus 'A'
   function automatic int ext_pos(input byte letter);
      return int'(letter) - 65;
   endfunction

   function automatic ext_vec_t ext_bit(input byte letter);
      ext_vec_t v;
      v = '0;
      v[ext_pos(letter)] = 1'b1;
      return v;
   endfunction

   // optional extensions software may toggle
   localparam ext_vec_t OPT_EXT  = ext_bit("M") | ext_bit("A") | ext_bit("F")
                                 | ext_bit("D") | ext_bit("C");
   // privilege-mode letters always advertised
   localparam ext_vec_t PRIV_EXT = ext_bit("S") | ext_bit("U");

   localparam int POS_F = 5;
   localparam int POS_D = 3;

endpackage

// File: rtl/isa_wr_legalize.sv
module isa_wr_legalize
   import isa_cap_pkg::*;
#(
   parameter ext_vec_t WMASK = OPT_EXT
) (
   input  ext_vec_t cur,
   input  logic     we,
   input  ext_vec_t wd,
   output ext_vec_t nxt
);

   ext_vec_t wd_fix;

   // double precision cannot stand without single precision
   always_comb begin
      wd_fix = wd;
      if (!wd[POS_F]) wd_fix[POS_D] = 1'b0;
   end

   for (genvar i = 0; i < EXT_W; i++) begin : g_bit
      if (WMASK[i]) begin : g_rw
         assign nxt[i] = we ? wd_fix[i] : cur[i];
      end else begin : g_ro
         assign nxt[i] = cur[i];
      end
   end

endmodule

// File: rtl/isa_cap_store.sv
module isa_cap_store
   import isa_cap_pkg::*;
#(
   parameter ext_vec_t RESET_VAL = PRIV_EXT
) (
   input  logic     clk,
   input  logic     rst_n,
   input  ext_vec_t nxt,
   output ext_vec_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RESET_VAL;
      else        q <= nxt;
   end

endmodule

// File: rtl/isa_cap_reg.sv
module isa_cap_reg
   import isa_cap_pkg::*;
#(
   parameter int       XLEN    = 64,
   parameter ext_vec_t MAX_EXT = 26'h000112D
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] rd_data,
   output logic [25:0]     ext_en
);

   localparam ext_vec_t CAP   = MAX_EXT | PRIV_EXT;
   localparam ext_vec_t WMASK = OPT_EXT & CAP;
   localparam int       PAD_W = XLEN - 2 - EXT_W;

   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("isa_cap_reg: XLEN must be 32 or 64");
   end

   ext_vec_t   ext_q;
   ext_vec_t   ext_nxt;
   logic [1:0] mxl;
   logic       unused_hi;

   assign unused_hi = ^wr_data[XLEN-1:EXT_W];

   if (XLEN == 32) begin : g_mxl32
      assign mxl = 2'd1;
   end else begin : g_mxl64
      assign mxl = 2'd2;
   end

   isa_wr_legalize #(.WMASK(WMASK)) u_legal (
      .cur (ext_q),
      .we  (wr_en),
      .wd  (wr_data[EXT_W-1:0]),
      .nxt (ext_nxt)
   );

   isa_cap_store #(.RESET_VAL(CAP)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt   (ext_nxt),
      .q     (ext_q)
   );

   assign rd_data = {mxl, {PAD_W{1'b0}}, ext_q};
   assign ext_en  = ext_q;

   // R3
   cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_q & ~CAP) == '0);

   // R4
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_q & ~WMASK) == (CAP & ~WMASK));

   // R5
   d_needs_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[POS_F]) |=> !ext_q[POS_D]);

   // R6
   write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[POS_F]) |=> (((ext_q ^ $past(wr_data[EXT_W-1:0])) & WMASK) == '0));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ext_q));

   // R2
   reset_val_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (ext_q == CAP));

endmodule

// File: tb/sim_isa_cap_reg.sv
module sim_isa_cap_reg;

   localparam int          XLEN    = 64;
   localparam logic [25:0] MAX_EXT = 26'h000112D;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [XLEN-1:0] wr_data = '0;
   logic [XLEN-1:0] rd_data;
   logic [25:0]     ext_en;

   int compared = 0;
   int mismatched = 0;
   logic done = 1'b0;

   logic [25:0] cap_b;
   logic [25:0] mdl;

   always #2 clk = ~clk;

   isa_cap_reg #(.XLEN(XLEN), .MAX_EXT(MAX_EXT)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .ext_en(ext_en)
   );

   task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [25:0] model_write(input logic [25:0] cur, input logic [25:0] wd);
      string letters;
      logic [25:0] r;
      logic f_on;
      letters = "MAFDC";
      r = cur;
      f_on = wd[5];
      for (int k = 0; k < letters.len(); k++) begin
         int p;
         p = int'(letters[k]) - 65;
         if (cap_b[p]) begin
            if (p == 3 && !f_on) r[p] = 1'b0;
            else                 r[p] = wd[p];
         end
      end
      return r;
   endfunction

   // one clock: drive at negedge, model at posedge, compare at next negedge (R1 R3 R4 R6 R7 R8)
   task automatic step(input logic we, input logic [XLEN-1:0] wd);
      wr_en = we;
      wr_data = wd;
      @(posedge clk);
      if (we) mdl = model_write(mdl, wd[25:0]);
      @(negedge clk);
      check("R1 R3 R4 R5 R6 R8 ext_en", {38'b0, ext_en}, {38'b0, mdl});
      check("R7 R8 rd_data", rd_data, {2'd2, 36'b0, mdl});
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      cap_b = MAX_EXT | (26'd1 << 18) | (26'd1 << 20);
      mdl = cap_b;
      repeat (3) @(negedge clk);
      // R2 value during reset
      check("R2 reset value", {38'b0, ext_en}, {38'b0, cap_b});
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 after release", {38'b0, ext_en}, {38'b0, cap_b});
      check("R7 width field", {62'b0, rd_data[63:62]}, 64'd2);

      // R4: write zeros, non-writable I, S, U stay set
      step(1'b1, '0);
      check("R4 I S U kept", {61'b0, ext_en[8], ext_en[18], ext_en[20]}, 64'd7);
      // R8: hold without write
      step(1'b0, '1);
      step(1'b0, '1);
      // R3: all ones restores only the maximum
      step(1'b1, '1);
      check("R3 all ones bounded", {38'b0, ext_en}, {38'b0, cap_b});
      // R5: D requested without F
      step(1'b1, 64'h8);
      check("R5 D cleared", {63'b0, ext_en[3]}, 64'd0);
      // R1: only M requested
      step(1'b1, 64'h1000);
      check("R1 M at bit 12", {63'b0, ext_en[12]}, 64'd1);
      check("R1 C at bit 2 off", {63'b0, ext_en[2]}, 64'd0);
      // R6: F and D together re-enable both
      step(1'b1, 64'h28);
      check("R6 F D set", {62'b0, ext_en[5], ext_en[3]}, 64'd3);

      for (int n = 0; n < 400; n++) begin
         step(1'(($urandom % 4) != 0), {$urandom, $urandom});
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule